// File: doc/BRIEF.md
# Accumulator Core Execute Stage

This block is the execute stage of a small 8-bit core built around a single accumulator. Each issued cycle it receives a 14-bit instruction word, the current accumulator value, the byte read from the addressed file register and the current carry flag. From these it computes a result byte. It also says where that byte goes: to the accumulator, back to the file register, or nowhere. It reports new carry, digit-carry and zero flag values, each with its own update strobe, and raises a request to skip the next instruction.

The surrounding core fetches instructions, reads the register file and commits what this stage returns. The outputs are registered, so they appear one clock after the issue strobe. Program flow, subroutine linkage, power-down and timer control belong to other blocks. Instruction words of those kinds leave this stage with no effect.

Top module: `acc_exu`

## Requirements
- R1: While reset is asserted, and until the first issued instruction after reset, every output is zero.
- R2: An instruction presented with `issue` high drives its outputs, with `out_valid` high, on the following clock. A cycle with `issue` low produces `out_valid` low and every write, flag and skip output low one clock later.
- R3: For an issued word, `reg_addr` equals bits 6..0. Byte-class words (bits 13..12 = 01) send their result to the accumulator when bit 7 is 0 and to the register when bit 7 is 1. At most one of `acc_we`/`reg_we` is ever high.
- R4: Add (byte code 0101 in bits 11..8) returns acc+reg. C is the carry out of bit 7, DC is the carry out of bit 3, and Z is updated.
- R5: Subtract (code 1010) returns reg−acc. C=1 when no borrow occurs and DC=1 when the low nibble needs no borrow. Z is updated.
- R6: Rotate left (1100) shifts C into bit 0 and bit 7 into C. Rotate right (1110) shifts C into bit 7 and bit 0 into C. Only C is updated.
- R7: Complement (0010), move (0011), increment (1000), decrement (0110), AND (0100), OR (1111) and XOR (1011) update only Z. Clear (code 0001) writes zero and sets Z: it clears the accumulator when bits 7..0 are all zero and clears the register when bit 7 is 1. When Z is updated, `z_out` is 1 exactly when the result is zero.
- R8: Swap nibbles (1101), increment-skip (1001) and decrement-skip (0111) update no flag. The two skip forms raise `skip_next` when their result is zero.
- R9: Literal words (bits 13..12 = 00) combine the accumulator with the immediate in bits 7..0 and write the accumulator: 1001 AND, 1000 XOR and 0011 OR update Z, and 0001 loads the immediate with no flag change.
- R10: Bit words (bits 13..12 = 11) use bits 9..7 as the bit index. Bits 11..10 = 11 clears that bit and 10 sets it, writing the register with no flag change. 01 skips when the bit is clear and 00 skips when it is set, with no write.
- R11: Class 10, byte code 0000, code 0001 with bit 7 low and bits 6..0 nonzero, and all other literal codes give no write, no flag strobe and no skip.
- R12: Any flag value without its strobe reads 0, and `result` reads 0 when neither write enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| issue | input | 1 | Instruction valid this cycle |
| instr | input | 14 | Instruction word |
| acc_in | input | 8 | Current accumulator |
| reg_in | input | 8 | Operand read from the addressed file register |
| c_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Outputs belong to an issued instruction |
| result | output | 8 | Result byte |
| acc_we | output | 1 | Write result to accumulator |
| reg_we | output | 1 | Write result to file register |
| reg_addr | output | 7 | Register address of the instruction |
| c_we | output | 1 | Carry update strobe |
| c_out | output | 1 | New carry |
| dc_we | output | 1 | Digit-carry update strobe |
| dc_out | output | 1 | New digit carry |
| z_we | output | 1 | Zero update strobe |
| z_out | output | 1 | New zero flag |
| skip_next | output | 1 | Skip the next instruction |

## Verification
Every cycle, the assertions check four things. At most one destination is written. An idle cycle strobes nothing. A zero-flag update always matches the result byte. The flag subsets hold together: a digit-carry update comes only with carry and zero, a carry-only update comes from a rotate, and a skip never touches a flag. Only the bench's sweeps can show the arithmetic values: sums, differences and borrows, rotated carries, bit masks, skip conditions and routing by the destination bit. These sweeps cover every opcode against a reference computed from the requirements.

// File: rtl/acc_exu_pkg.sv
package acc_exu_pkg;
  parameter int DATA_W = 8;
  parameter int ADDR_W = 7;
  parameter int INSN_W = 14;
  localparam int BIT_W = $clog2(DATA_W);
  localparam int NIB_W = DATA_W / 2;

  typedef enum logic [4:0] {
    OP_NOP, OP_COM, OP_MOVR, OP_RRR, OP_RLR, OP_SWAP,
    OP_INC, OP_INCSZ, OP_DEC, OP_DECSZ, OP_SUB, OP_XOR,
    OP_AND, OP_ADD, OP_IOR, OP_CLRA, OP_CLRR,
    OP_LAND, OP_LXOR, OP_LMOV, OP_LIOR,
    OP_BCLR, OP_BSET, OP_BTSC, OP_BTSS
  } exu_op_e;

  typedef struct packed {
    exu_op_e             op;
    logic                to_reg;
    logic [ADDR_W-1:0]   addr;
    logic [DATA_W-1:0]   imm;
    logic [BIT_W-1:0]    bsel;
  } exu_ctrl_t;

  typedef struct packed {
    logic [DATA_W-1:0] result;
    logic              acc_we;
    logic              reg_we;
    logic              c_we;
    logic              c_val;
    logic              dc_we;
    logic              dc_val;
    logic              z_we;
    logic              z_val;
    logic              skip;
  } exu_res_t;
endpackage

// File: rtl/exu_decode.sv
module exu_decode
  import acc_exu_pkg::*;
(
  input  logic [INSN_W-1:0] instr,
  output exu_ctrl_t         ctrl
);
  logic [1:0] cls;
  logic [3:0] sub;

  assign cls = instr[INSN_W-1 -: 2];
  assign sub = instr[INSN_W-3 -: 4];

  always_comb begin
    ctrl        = '0;
    ctrl.op     = OP_NOP;
    ctrl.to_reg = instr[7];
    ctrl.addr   = instr[ADDR_W-1:0];
    ctrl.imm    = instr[DATA_W-1:0];
    ctrl.bsel   = instr[7 +: BIT_W];
    case (cls)
      2'b01: begin
        case (sub)
          4'h1: begin
            if (instr[7])                     ctrl.op = OP_CLRR;
            else if (instr[ADDR_W-1:0] == '0) ctrl.op = OP_CLRA;
            else                              ctrl.op = OP_NOP;
          end
          4'h2:    ctrl.op = OP_COM;
          4'h3:    ctrl.op = OP_MOVR;
          4'h4:    ctrl.op = OP_AND;
          4'h5:    ctrl.op = OP_ADD;
          4'h6:    ctrl.op = OP_DEC;
          4'h7:    ctrl.op = OP_DECSZ;
          4'h8:    ctrl.op = OP_INC;
          4'h9:    ctrl.op = OP_INCSZ;
          4'hA:    ctrl.op = OP_SUB;
          4'hB:    ctrl.op = OP_XOR;
          4'hC:    ctrl.op = OP_RLR;
          4'hD:    ctrl.op = OP_SWAP;
          4'hE:    ctrl.op = OP_RRR;
          4'hF:    ctrl.op = OP_IOR;
          default: ctrl.op = OP_NOP;
        endcase
      end
      2'b00: begin
        case (sub)
          4'h9:    ctrl.op = OP_LAND;
          4'h8:    ctrl.op = OP_LXOR;
          4'h1:    ctrl.op = OP_LMOV;
          4'h3:    ctrl.op = OP_LIOR;
          default: ctrl.op = OP_NOP;
        endcase
      end
      2'b11: begin
        case (sub[3:2])
          2'b11:   ctrl.op = OP_BCLR;
          2'b10:   ctrl.op = OP_BSET;
          2'b01:   ctrl.op = OP_BTSC;
          default: ctrl.op = OP_BTSS;
        endcase
      end
      default: ctrl.op = OP_NOP;
    endcase
  end
endmodule

// File: rtl/exu_nib_adder.sv
module exu_nib_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         c_half,
  output logic         c_full
);
  localparam int H = W / 2;
  logic [H:0]   lo;
  logic [W-H:0] hi;

  assign lo     = {1'b0, a[H-1:0]} + {1'b0, b[H-1:0]} + {{H{1'b0}}, cin};
  assign hi     = {1'b0, a[W-1:H]} + {1'b0, b[W-1:H]} + {{(W-H){1'b0}}, lo[H]};
  assign sum    = {hi[W-H-1:0], lo[H-1:0]};
  assign c_half = lo[H];
  assign c_full = hi[W-H];
endmodule

// File: rtl/exu_alu.sv
module exu_alu
  import acc_exu_pkg::*;
(
  input  exu_ctrl_t         ctrl,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] opnd,
  input  logic              cin,
  output exu_res_t          res
);
  typedef enum logic [1:0] {DST_NONE, DST_D, DST_ACC, DST_REG} dst_e;

  logic [DATA_W-1:0] add_sum, sub_dif, inc_v, dec_v, bmask, val;
  logic add_h, add_f, sub_h, sub_f, inc_h, inc_f, dec_h, dec_f;
  logic bit_now, zupd;
  dst_e dst;

  exu_nib_adder #(.W(DATA_W)) u_add (
    .a(acc), .b(opnd), .cin(1'b0), .sum(add_sum), .c_half(add_h), .c_full(add_f));
  exu_nib_adder #(.W(DATA_W)) u_sub (
    .a(opnd), .b(~acc), .cin(1'b1), .sum(sub_dif), .c_half(sub_h), .c_full(sub_f));
  exu_nib_adder #(.W(DATA_W)) u_inc (
    .a(opnd), .b('0), .cin(1'b1), .sum(inc_v), .c_half(inc_h), .c_full(inc_f));
  exu_nib_adder #(.W(DATA_W)) u_dec (
    .a(opnd), .b('1), .cin(1'b0), .sum(dec_v), .c_half(dec_h), .c_full(dec_f));

  assign bmask   = {{(DATA_W-1){1'b0}}, 1'b1} << ctrl.bsel;
  assign bit_now = |(opnd & bmask);

  always_comb begin
    res  = '0;
    val  = '0;
    zupd = 1'b0;
    dst  = DST_NONE;
    case (ctrl.op)
      OP_COM:   begin val = ~opnd;        dst = DST_D; zupd = 1'b1; end
      OP_MOVR:  begin val = opnd;         dst = DST_D; zupd = 1'b1; end
      OP_AND:   begin val = opnd & acc;   dst = DST_D; zupd = 1'b1; end
      OP_IOR:   begin val = opnd | acc;   dst = DST_D; zupd = 1'b1; end
      OP_XOR:   begin val = opnd ^ acc;   dst = DST_D; zupd = 1'b1; end
      OP_INC:   begin val = inc_v;        dst = DST_D; zupd = 1'b1; end
      OP_DEC:   begin val = dec_v;        dst = DST_D; zupd = 1'b1; end
      OP_CLRA:  begin val = '0;           dst = DST_ACC; zupd = 1'b1; end
      OP_CLRR:  begin val = '0;           dst = DST_REG; zupd = 1'b1; end
      OP_SWAP:  begin val = {opnd[NIB_W-1:0], opnd[DATA_W-1:NIB_W]}; dst = DST_D; end
      OP_INCSZ: begin val = inc_v; dst = DST_D; res.skip = (inc_v == '0); end
      OP_DECSZ: begin val = dec_v; dst = DST_D; res.skip = (dec_v == '0); end
      OP_RRR: begin
        val = {cin, opnd[DATA_W-1:1]}; dst = DST_D;
        res.c_we = 1'b1; res.c_val = opnd[0];
      end
      OP_RLR: begin
        val = {opnd[DATA_W-2:0], cin}; dst = DST_D;
        res.c_we = 1'b1; res.c_val = opnd[DATA_W-1];
      end
      OP_ADD: begin
        val = add_sum; dst = DST_D; zupd = 1'b1;
        res.c_we = 1'b1; res.c_val = add_f;
        res.dc_we = 1'b1; res.dc_val = add_h;
      end
      OP_SUB: begin
        val = sub_dif; dst = DST_D; zupd = 1'b1;
        res.c_we = 1'b1; res.c_val = sub_f;
        res.dc_we = 1'b1; res.dc_val = sub_h;
      end
      OP_LAND: begin val = acc & ctrl.imm; dst = DST_ACC; zupd = 1'b1; end
      OP_LXOR: begin val = acc ^ ctrl.imm; dst = DST_ACC; zupd = 1'b1; end
      OP_LIOR: begin val = acc | ctrl.imm; dst = DST_ACC; zupd = 1'b1; end
      OP_LMOV: begin val = ctrl.imm;       dst = DST_ACC; end
      OP_BCLR: begin val = opnd & ~bmask;  dst = DST_REG; end
      OP_BSET: begin val = opnd | bmask;   dst = DST_REG; end
      OP_BTSC: res.skip = ~bit_now;
      OP_BTSS: res.skip = bit_now;
      default: ;
    endcase

    case (dst)
      DST_D:   begin res.acc_we = ~ctrl.to_reg; res.reg_we = ctrl.to_reg; end
      DST_ACC: res.acc_we = 1'b1;
      DST_REG: res.reg_we = 1'b1;
      default: ;
    endcase

    if (dst != DST_NONE) res.result = val;
    if (zupd) begin
      res.z_we  = 1'b1;
      res.z_val = (val == '0);
    end
  end
endmodule

// File: rtl/acc_exu.sv
module acc_exu
  import acc_exu_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                issue,
  input  logic [INSN_W-1:0]   instr,
  input  logic [DATA_W-1:0]   acc_in,
  input  logic [DATA_W-1:0]   reg_in,
  input  logic                c_in,
  output logic                out_valid,
  output logic [DATA_W-1:0]   result,
  output logic                acc_we,
  output logic                reg_we,
  output logic [ADDR_W-1:0]   reg_addr,
  output logic                c_we,
  output logic                c_out,
  output logic                dc_we,
  output logic                dc_out,
  output logic                z_we,
  output logic                z_out,
  output logic                skip_next
);
  typedef struct packed {
    logic              valid;
    logic [ADDR_W-1:0] addr;
    exu_res_t          r;
  } stage_t;

  logic [1:0] rst_sync;
  logic       rst_int_n;
  exu_ctrl_t  ctrl;
  exu_res_t   alu_res;
  stage_t     q, q_nxt;
  logic       stage_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  exu_decode u_dec (.instr(instr), .ctrl(ctrl));
  exu_alu    u_alu (.ctrl(ctrl), .acc(acc_in), .opnd(reg_in), .cin(c_in), .res(alu_res));

  assign stage_en = issue | q.valid;

  always_comb begin
    q_nxt = '0;
    if (issue) begin
      q_nxt.valid = 1'b1;
      q_nxt.addr  = ctrl.addr;
      q_nxt.r     = alu_res;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)    q <= '0;
    else if (stage_en) q <= q_nxt;
  end

  assign out_valid = q.valid;
  assign reg_addr  = q.addr;
  assign result    = q.r.result;
  assign acc_we    = q.r.acc_we;
  assign reg_we    = q.r.reg_we;
  assign c_we      = q.r.c_we;
  assign c_out     = q.r.c_val;
  assign dc_we     = q.r.dc_we;
  assign dc_out    = q.r.dc_val;
  assign z_we      = q.r.z_we;
  assign z_out     = q.r.z_val;
  assign skip_next = q.r.skip;

  a_r3_one_dest: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0({acc_we, reg_we}));
  a_r2_issue_valid: assert property (@(posedge clk) disable iff (!rst_int_n)
    issue |=> out_valid);
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_int_n)
    !out_valid |-> !(acc_we || reg_we || c_we || dc_we || z_we || skip_next));
  a_r7_zero_match: assert property (@(posedge clk) disable iff (!rst_int_n)
    z_we |-> (z_out == (result == '0)));
  a_r4_dc_group: assert property (@(posedge clk) disable iff (!rst_int_n)
    dc_we |-> (c_we && z_we));
  a_r6_carry_only: assert property (@(posedge clk) disable iff (!rst_int_n)
    (c_we && !dc_we) |-> !z_we);
  a_r8_skip_no_flags: assert property (@(posedge clk) disable iff (!rst_int_n)
    skip_next |-> !(c_we || dc_we || z_we));
  a_r12_flag_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!c_we |-> !c_out) and (!dc_we |-> !dc_out) and (!z_we |-> !z_out));
endmodule

// File: tb/acc_exu_tb.sv
module acc_exu_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issue = 1'b0;
  logic [13:0] instr = '0;
  logic [7:0] acc_in = '0, reg_in = '0;
  logic c_in = 1'b0;
  logic out_valid, acc_we, reg_we, c_we, c_out, dc_we, dc_out, z_we, z_out, skip_next;
  logic [7:0] result;
  logic [6:0] reg_addr;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  acc_exu u_dut (
    .clk(clk), .rst_n(rst_n), .issue(issue), .instr(instr), .acc_in(acc_in),
    .reg_in(reg_in), .c_in(c_in), .out_valid(out_valid), .result(result),
    .acc_we(acc_we), .reg_we(reg_we), .reg_addr(reg_addr), .c_we(c_we),
    .c_out(c_out), .dc_we(dc_we), .dc_out(dc_out), .z_we(z_we), .z_out(z_out),
    .skip_next(skip_next));

  function automatic logic [7:0] pick(input int k);
    case (k)
      0: pick = 8'h00; 1: pick = 8'hFF; 2: pick = 8'h0F; 3: pick = 8'hF0;
      4: pick = 8'h80; 5: pick = 8'h7F; 6: pick = 8'h01; 7: pick = 8'h08;
      default: pick = 8'((k * 53 + 11) & 255);
    endcase
  endfunction

  // {valid, addr[6:0], result[7:0], acc_we, reg_we, c_we, c, dc_we, dc, z_we, z, skip}
  function automatic logic [24:0] model(input logic [13:0] w, input logic [7:0] a,
                                        input logic [7:0] r, input logic ci);
    logic [7:0] res; logic act, tor, usez, cw, cv, dw, dv, sk, aw, rw;
    logic [8:0] s; int b;
    res = 0; act = 0; tor = w[7]; usez = 0; cw = 0; cv = 0; dw = 0; dv = 0; sk = 0;
    aw = 0; rw = 0; b = int'(w[9:7]);
    case (w[13:12])
      2'b01: case (w[11:8])
        4'h2: begin res = ~r; act = 1; usez = 1; end
        4'h3: begin res = r; act = 1; usez = 1; end
        4'h4: begin res = r & a; act = 1; usez = 1; end
        4'hF: begin res = r | a; act = 1; usez = 1; end
        4'hB: begin res = r ^ a; act = 1; usez = 1; end
        4'h8: begin res = r + 8'd1; act = 1; usez = 1; end
        4'h6: begin res = r - 8'd1; act = 1; usez = 1; end
        4'h9: begin res = r + 8'd1; act = 1; sk = (res == 0); end
        4'h7: begin res = r - 8'd1; act = 1; sk = (res == 0); end
        4'hD: begin res = {r[3:0], r[7:4]}; act = 1; end
        4'hE: begin res = {ci, r[7:1]}; act = 1; cw = 1; cv = r[0]; end
        4'hC: begin res = {r[6:0], ci}; act = 1; cw = 1; cv = r[7]; end
        4'h5: begin s = {1'b0, a} + {1'b0, r}; res = s[7:0]; act = 1; usez = 1;
                    cw = 1; cv = s[8]; dw = 1; dv = ({1'b0, a[3:0]} + {1'b0, r[3:0]}) > 5'd15; end
        4'hA: begin res = r - a; act = 1; usez = 1; cw = 1; cv = (r >= a);
                    dw = 1; dv = (r[3:0] >= a[3:0]); end
        4'h1: if (w[7] || w[6:0] == 0) begin res = 0; act = 1; usez = 1; end
        default: ;
      endcase
      2'b00: begin
        tor = 0;
        case (w[11:8])
          4'h9: begin res = a & w[7:0]; act = 1; usez = 1; end
          4'h8: begin res = a ^ w[7:0]; act = 1; usez = 1; end
          4'h3: begin res = a | w[7:0]; act = 1; usez = 1; end
          4'h1: begin res = w[7:0]; act = 1; end
          default: ;
        endcase
      end
      2'b11: begin
        tor = 1;
        case (w[11:10])
          2'b11: begin res = r; res[b] = 1'b0; act = 1; end
          2'b10: begin res = r; res[b] = 1'b1; act = 1; end
          2'b01: sk = ~r[b];
          default: sk = r[b];
        endcase
      end
      default: ;
    endcase
    if (act) begin aw = ~tor; rw = tor; end
    model = {1'b1, w[6:0], res, aw, rw, cw, cv, dw, dv, usez, usez && (res == 0), sk};
  endfunction

  function automatic string tag_of(input logic [13:0] w);
    case (w[13:12])
      2'b01: case (w[11:8])
        4'h5: tag_of = "R4"; 4'hA: tag_of = "R5";
        4'hC, 4'hE: tag_of = "R6";
        4'hD, 4'h9, 4'h7: tag_of = "R8";
        4'h0: tag_of = "R11";
        default: tag_of = "R7";
      endcase
      2'b00: tag_of = (w[11:8] inside {4'h9, 4'h8, 4'h3, 4'h1}) ? "R9" : "R11";
      2'b11: tag_of = "R10";
      default: tag_of = "R11";
    endcase
  endfunction

  function automatic logic [24:0] got();
    got = {out_valid, reg_addr, result, acc_we, reg_we, c_we, c_out, dc_we, dc_out,
           z_we, z_out, skip_next};
  endfunction

  task automatic check(input string tag, input logic [24:0] exp);
    n_chk++;
    if (got() !== exp) begin
      n_bad++;
      $display("FAIL %s instr=%h acc=%h reg=%h cin=%b got=%h exp=%h (R3 R12 routing/zeroing included)",
               tag, instr, acc_in, reg_in, c_in, got(), exp);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge (one register stage)
  task automatic run_vec(input logic [13:0] w, input logic [7:0] a, input logic [7:0] r,
                         input logic ci);
    issue = 1'b1; instr = w; acc_in = a; reg_in = r; c_in = ci;
    @(negedge clk);
    check(tag_of(w), model(w, a, r, ci));
  endtask

  task automatic run_idle(input logic [13:0] w);
    issue = 1'b0; instr = w; acc_in = 8'h55; reg_in = 8'hAA; c_in = 1'b1;
    @(negedge clk);
    check("R2", 25'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog expired: got=hung exp=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: reset holds outputs at zero
    repeat (3) @(negedge clk);
    check("R1", 25'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", 25'd0);

    // R3 R4 R5 R6 R7 R8 R11: byte class sweep
    for (int code = 0; code < 16; code++)
      for (int d = 0; d < 2; d++)
        for (int ci = 0; ci < 2; ci++)
          for (int ai = 0; ai < 16; ai++)
            for (int ri = 0; ri < 16; ri++) begin
              logic [6:0] ad;
              ad = (ai == 0) ? 7'd0 : 7'((ai * 7 + ri) & 127);
              run_vec({2'b01, 4'(code), 1'(d), ad}, pick(ai), pick(ri), 1'(ci));
            end
    run_idle(14'h1580);   // R2: idle after traffic

    // R9 R11: literal class sweep
    for (int code = 0; code < 16; code++)
      for (int ii = 0; ii < 16; ii++)
        for (int ai = 0; ai < 16; ai++)
          run_vec({2'b00, 4'(code), pick(ii)}, pick(ai), pick(15 - ii), 1'b0);
    run_idle(14'h0901);

    // R10: bit class sweep
    for (int code = 0; code < 4; code++)
      for (int b = 0; b < 8; b++)
        for (int ri = 0; ri < 16; ri++)
          run_vec({2'b11, 2'(code), 3'(b), 7'((ri * 5) & 127)}, pick(15 - ri), pick(ri), 1'(ri & 1));

    // R11: program-flow class has no effect here
    for (int k = 0; k < 64; k++)
      run_vec({2'b10, 12'((k * 389 + 7) & 4095)}, pick(k & 15), pick((k >> 2) & 15), 1'(k & 1));

    run_idle(14'h3F80);
    run_idle(14'h1580);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule